// File: doc/BRIEF.md
# Buffered PWM Pulse Generator

This block produces pulse-width-modulated outputs from a period value and a duty value held in byte-wide buffer registers. Software loads the buffers through a plain write port (address, byte, strobe) and can read them back through a separate read address. The block runs either as two independent 8-bit channels, each with its own period and duty, or as a single 16-bit channel that drives output 0 while output 1 rests at its inactive level.

The values written by software are only buffered. Each channel copies its period and duty into working registers at the start of every period, so a change never cuts a period short or stretches it. In 16-bit mode the duty is staged: the high byte is parked in a holding register, and the write of the low byte commits both halves in one clock. A duty of zero keeps the output inactive. A duty equal to the period keeps it active for the whole period. Any duty above the period keeps it inactive. Per-output inversion bits flip the level.

Top module: `pwm_unit`

## Requirements
- R1: After reset both duty bytes (address 3 and 4) and both period bytes (addresses 1 and 2) read 0xFF, the control byte (address 0) reads 0x00 and both outputs are low.
- R2: In 16-bit mode (control bit 1 set) the duty is {byte at address 4, byte at address 3}: bits 15:8 come from address 4 and bits 7:0 from address 3. A write to address 3 commits the staged high byte and the new low byte together in the same clock.
- R3: In 16-bit mode a write to address 4 alone leaves the committed 16-bit duty unchanged. The next period still uses the last committed value.
- R4: A duty of zero keeps the output inactive for the whole period.
- R5: A duty equal to the period keeps the output active for the whole period.
- R6: A duty greater than the period keeps the output inactive for the whole period. With normal polarity that level is low.
- R7: A duty or period written while a channel runs takes effect only from the first cycle of the next period.
- R8: Control bit 2 inverts output 0 and control bit 3 inverts output 1. The duty gives the high-pulse width when the inversion bit is clear.
- R9: With control bit 0 (enable) set, a period lasts exactly the period value in cycles. The counter starts at zero in the cycle after enable and loads the buffered values there. The output is active while the count is below the duty.
- R10: In 8-bit mode channel 0 uses addresses 1 (period) and 3 (duty) and drives output 0, and channel 1 uses addresses 2 and 4 and drives output 1. Each duty write commits directly. In 16-bit mode the period is {address 2, address 1} and output 1 stays at its inactive level.
- R11: Clearing the enable bit forces every output to its inactive level from the cycle after the write, and the next enable starts a fresh period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write byte |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read byte for rd_addr (combinational) |
| pwm_o | output | 2 | PWM outputs, bit 0 channel 0 or the 16-bit channel |

## Verification
The bench builds the block with the default byte width of 8, which gives two 8-bit channels and one 16-bit channel. Small periods of four to six cycles bring every period boundary, a mid-period duty or period write, and the zero, equal and over-range duty cases within a few dozen cycles. A 16-bit period of 288 with a duty of 256 can only be met if the high byte really supplies bits 15:8. Staging a high byte alone and then committing a low byte mid-run makes the pending-value rule visible at the output.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_PER_LO  = 3'd1,
    REG_PER_HI  = 3'd2,
    REG_DUTY_LO = 3'd3,
    REG_DUTY_HI = 3'd4
  } reg_addr_e;

  // control byte bit positions
  localparam int CTRL_EN   = 0;
  localparam int CTRL_M16  = 1;
  localparam int CTRL_INV0 = 2;
  localparam int CTRL_INV1 = 3;
  localparam int CTRL_BITS = 4;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ctrl_en,
  output logic              mode16,
  output logic              inv0,
  output logic              inv1,
  output logic [BYTE_W-1:0] per_lo_buf,
  output logic [BYTE_W-1:0] per_hi_buf,
  output logic [BYTE_W-1:0] duty_lo_buf,
  output logic [BYTE_W-1:0] duty_hi_buf,
  output logic [BYTE_W-1:0] duty_stage
);
  localparam logic [BYTE_W-1:0] BUF_RST = '1;

  logic [CTRL_BITS-1:0] ctrl_q, ctrl_d;
  logic [BYTE_W-1:0]    per_lo_q, per_lo_d, per_hi_q, per_hi_d;
  logic [BYTE_W-1:0]    duty_lo_q, duty_lo_d, duty_hi_q, duty_hi_d;
  logic [BYTE_W-1:0]    stage_q, stage_d;
  logic                 m16_now;

  assign m16_now = ctrl_q[CTRL_M16];

  always_comb begin
    ctrl_d    = ctrl_q;
    per_lo_d  = per_lo_q;
    per_hi_d  = per_hi_q;
    duty_lo_d = duty_lo_q;
    duty_hi_d = duty_hi_q;
    stage_d   = stage_q;
    if (wr_en) begin
      case (wr_addr)
        REG_CTRL:    ctrl_d   = wr_data[CTRL_BITS-1:0];
        REG_PER_LO:  per_lo_d = wr_data;
        REG_PER_HI:  per_hi_d = wr_data;
        REG_DUTY_LO: begin
          duty_lo_d = wr_data;
          if (m16_now) duty_hi_d = stage_q;
        end
        REG_DUTY_HI: begin
          stage_d = wr_data;
          if (!m16_now) duty_hi_d = wr_data;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      per_lo_q  <= BUF_RST;
      per_hi_q  <= BUF_RST;
      duty_lo_q <= BUF_RST;
      duty_hi_q <= BUF_RST;
      stage_q   <= BUF_RST;
    end else if (wr_en) begin
      ctrl_q    <= ctrl_d;
      per_lo_q  <= per_lo_d;
      per_hi_q  <= per_hi_d;
      duty_lo_q <= duty_lo_d;
      duty_hi_q <= duty_hi_d;
      stage_q   <= stage_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CTRL:    rd_data[CTRL_BITS-1:0] = ctrl_q;
      REG_PER_LO:  rd_data = per_lo_q;
      REG_PER_HI:  rd_data = per_hi_q;
      REG_DUTY_LO: rd_data = duty_lo_q;
      REG_DUTY_HI: rd_data = stage_q;
      default:     rd_data = '0;
    endcase
  end

  assign ctrl_en     = ctrl_q[CTRL_EN];
  assign mode16      = ctrl_q[CTRL_M16];
  assign inv0        = ctrl_q[CTRL_INV0];
  assign inv1        = ctrl_q[CTRL_INV1];
  assign per_lo_buf  = per_lo_q;
  assign per_hi_buf  = per_hi_q;
  assign duty_lo_buf = duty_lo_q;
  assign duty_hi_buf = duty_hi_q;
  assign duty_stage  = stage_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         inv,
  input  logic [W-1:0] per_buf,
  input  logic [W-1:0] duty_buf,
  output logic         pwm
);
  logic         run_q, run_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] per_q, per_d;
  logic [W-1:0] duty_q, duty_d;
  logic [W:0]   cnt_inc;
  logic         at_end;
  logic         ce;
  logic         active;

  assign cnt_inc = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign at_end  = cnt_inc >= {1'b0, per_q};
  assign ce      = en | run_q;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    per_d  = per_q;
    duty_d = duty_q;
    if (!en) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (!run_q || at_end) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      per_d  = per_buf;
      duty_d = duty_buf;
    end else begin
      cnt_d = cnt_inc[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else if (ce) begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      duty_q <= duty_d;
    end
  end

  assign active = en && run_q && (duty_q <= per_q) && (cnt_q < duty_q);
  assign pwm    = active ^ inv;
endmodule

// File: rtl/pwm_unit.sv
module pwm_unit
  import pwm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [1:0]        pwm_o
);
  localparam int NCH  = 2;
  localparam int WIDE = 2 * BYTE_W;

  logic              rst_sync_n;
  logic              ctrl_en, mode16, inv0, inv1;
  logic [BYTE_W-1:0] per_lo_buf, per_hi_buf, duty_lo_buf, duty_hi_buf, duty_stage;
  logic [NCH-1:0][BYTE_W-1:0] per8, duty8;
  logic [NCH-1:0]    inv_v, pwm8;
  logic              pwm16;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pwm_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ctrl_en(ctrl_en), .mode16(mode16), .inv0(inv0), .inv1(inv1),
    .per_lo_buf(per_lo_buf), .per_hi_buf(per_hi_buf),
    .duty_lo_buf(duty_lo_buf), .duty_hi_buf(duty_hi_buf),
    .duty_stage(duty_stage)
  );

  assign per8[0]  = per_lo_buf;
  assign per8[1]  = per_hi_buf;
  assign duty8[0] = duty_lo_buf;
  assign duty8[1] = duty_hi_buf;
  assign inv_v    = {inv1, inv0};

  for (genvar g = 0; g < NCH; g++) begin : g_narrow
    pwm_chan #(.W(BYTE_W)) u_ch (
      .clk(clk), .rst_n(rst_sync_n),
      .en(ctrl_en & ~mode16), .inv(inv_v[g]),
      .per_buf(per8[g]), .duty_buf(duty8[g]),
      .pwm(pwm8[g])
    );
  end

  pwm_chan #(.W(WIDE)) u_wide (
    .clk(clk), .rst_n(rst_sync_n),
    .en(ctrl_en & mode16), .inv(inv0),
    .per_buf({per_hi_buf, per_lo_buf}),
    .duty_buf({duty_hi_buf, duty_lo_buf}),
    .pwm(pwm16)
  );

  assign pwm_o[0] = mode16 ? pwm16 : pwm8[0];
  assign pwm_o[1] = pwm8[1];
endmodule

// File: rtl/pwm_unit_chk.sv
module pwm_unit_chk
  import pwm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic              ctrl_en,
  input logic              mode16,
  input logic              inv0,
  input logic              inv1,
  input logic [BYTE_W-1:0] duty_lo_buf,
  input logic [BYTE_W-1:0] duty_hi_buf,
  input logic [BYTE_W-1:0] duty_stage,
  input logic [1:0]        pwm_o
);
  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_en |-> pwm_o == {inv1, inv0});

  // R3
  hi_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == REG_DUTY_HI && mode16) |=> $stable({duty_hi_buf, duty_lo_buf}));

  // R2
  lo_commit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == REG_DUTY_LO && mode16) |=>
      {duty_hi_buf, duty_lo_buf} == {$past(duty_stage), $past(wr_data)});

  // R10
  direct_hi_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == REG_DUTY_HI && !mode16) |=> duty_hi_buf == $past(wr_data));

  // R10
  idle_out1_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode16 |-> pwm_o[1] == inv1);
endmodule

bind pwm_unit pwm_unit_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ctrl_en(ctrl_en), .mode16(mode16), .inv0(inv0), .inv1(inv1),
  .duty_lo_buf(duty_lo_buf), .duty_hi_buf(duty_hi_buf),
  .duty_stage(duty_stage), .pwm_o(pwm_o)
);

// File: tb/sim_pwm_unit.sv
`timescale 1ns/1ps
module sim_pwm_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic [1:0] pwm_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
  );

  function automatic bit exp_bit(int per, int duty, int inv, int ph);
    bit act;
    act = (per > 0) && (duty <= per) && ((ph % per) < duty);
    return act ^ bit'(inv);
  endfunction

  // drive at the current negedge, write lands at the next posedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: rd_data[%0d]=%h expected %h", tag, a, rd_data, exp);
    end
  endtask

  // checks n samples, sample index j from j0; phase of channel k is j-basek
  task automatic expect_run(input int per0, input int duty0, input int base0,
                            input int per1, input int duty1, input int base1,
                            input int inv0, input int inv1,
                            input int j0, input int n, input string tag);
    for (int j = j0; j < j0 + n; j++) begin
      logic [1:0] e;
      e[0] = exp_bit(per0, duty0, inv0, j - base0);
      e[1] = exp_bit(per1, duty1, inv1, j - base1);
      checks++;
      if (pwm_o !== e) begin
        errors++;
        $display("FAIL %s: pwm_o=%b expected %b at sample %0d", tag, pwm_o, e, j);
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    checks++;
    if (pwm_o !== 2'b00) begin
      errors++;
      $display("FAIL R1: pwm_o=%b expected 00", pwm_o);
    end
    chk_rd(3'd0, 8'h00, "R1");
    chk_rd(3'd1, 8'hFF, "R1");
    chk_rd(3'd2, 8'hFF, "R1");
    chk_rd(3'd3, 8'hFF, "R1");
    chk_rd(3'd4, 8'hFF, "R1");
  endtask

  task automatic t_narrow;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'd5); wr(3'd3, 8'd2);
    wr(3'd2, 8'd6); wr(3'd4, 8'd3);
    wr(3'd0, 8'h01);
    @(negedge clk);
    expect_run(5, 2, 0, 6, 3, 0, 0, 0, 0, 30, "R9 R10");
  endtask

  task automatic t_midrun;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'd5); wr(3'd3, 8'd2);
    wr(3'd2, 8'd3); wr(3'd4, 8'd1);
    wr(3'd0, 8'h01);
    @(negedge clk);
    expect_run(5, 2, 0, 3, 1, 0, 0, 0, 0, 3, "R7");
    wr(3'd3, 8'd4);
    expect_run(5, 2, 0, 3, 1, 0, 0, 0, 4, 1, "R7 duty held");
    expect_run(5, 4, 0, 3, 1, 0, 0, 0, 5, 15, "R7 duty new");
    wr(3'd0, 8'h00);
    wr(3'd1, 8'd4); wr(3'd3, 8'd2);
    wr(3'd0, 8'h01);
    @(negedge clk);
    expect_run(4, 2, 0, 3, 1, 0, 0, 0, 0, 2, "R7");
    wr(3'd1, 8'd6);
    expect_run(4, 2, 0, 3, 1, 0, 0, 0, 3, 1, "R7 period held");
    expect_run(6, 2, 4, 3, 1, 0, 0, 0, 4, 18, "R7 period new");
  endtask

  task automatic t_limits;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'd4); wr(3'd3, 8'd0);
    wr(3'd2, 8'd4); wr(3'd4, 8'd4);
    wr(3'd0, 8'h01);
    @(negedge clk);
    expect_run(4, 0, 0, 4, 4, 0, 0, 0, 0, 12, "R4 R5");
    wr(3'd0, 8'h00);
    wr(3'd3, 8'd7);
    wr(3'd0, 8'h01);
    @(negedge clk);
    expect_run(4, 7, 0, 4, 4, 0, 0, 0, 0, 12, "R6");
  endtask

  task automatic t_invert;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'd5); wr(3'd3, 8'd9);
    wr(3'd2, 8'd4); wr(3'd4, 8'd1);
    wr(3'd0, 8'h0D);
    @(negedge clk);
    expect_run(5, 9, 0, 4, 1, 0, 1, 1, 0, 16, "R8 R6");
  endtask

  task automatic t_disable;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'd4); wr(3'd3, 8'd3);
    wr(3'd2, 8'd4); wr(3'd4, 8'd3);
    wr(3'd0, 8'h01);
    @(negedge clk);
    expect_run(4, 3, 0, 4, 3, 0, 0, 0, 0, 2, "R11");
    wr(3'd0, 8'h00);
    expect_run(4, 0, 0, 4, 0, 0, 0, 0, 0, 4, "R11 off");
    wr(3'd0, 8'h0C);
    expect_run(4, 0, 0, 4, 0, 0, 1, 1, 0, 4, "R11 off inverted");
    wr(3'd0, 8'h01);
    @(negedge clk);
    expect_run(4, 3, 0, 4, 3, 0, 0, 0, 0, 8, "R11 restart");
  endtask

  task automatic t_wide;
    wr(3'd0, 8'h02);
    wr(3'd2, 8'h00); wr(3'd1, 8'd20);
    wr(3'd4, 8'h00); wr(3'd3, 8'd7);
    wr(3'd0, 8'h03);
    @(negedge clk);
    expect_run(20, 7, 0, 1, 0, 0, 0, 0, 0, 40, "R2 R10");
    wr(3'd0, 8'h02);
    wr(3'd4, 8'h01);
    chk_rd(3'd4, 8'h01, "R3");
    wr(3'd0, 8'h03);
    @(negedge clk);
    expect_run(20, 7, 0, 1, 0, 0, 0, 0, 0, 20, "R3");
    wr(3'd3, 8'h02);
    expect_run(20, 7, 0, 1, 0, 0, 0, 0, 21, 19, "R3 R7 held");
    expect_run(20, 258, 0, 1, 0, 0, 0, 0, 40, 20, "R2 R6");
    wr(3'd0, 8'h02);
    wr(3'd4, 8'h00); wr(3'd3, 8'd20);
    wr(3'd0, 8'h03);
    @(negedge clk);
    expect_run(20, 20, 0, 1, 0, 0, 0, 0, 0, 40, "R5 wide");
    wr(3'd0, 8'h02);
    wr(3'd2, 8'h01); wr(3'd1, 8'h20);
    wr(3'd4, 8'h01); wr(3'd3, 8'h00);
    wr(3'd0, 8'h0B);
    @(negedge clk);
    expect_run(288, 256, 0, 1, 0, 0, 0, 1, 0, 600, "R2 R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_narrow();
    t_midrun();
    t_limits();
    t_invert();
    t_disable();
    t_wide();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule